// File: doc/BRIEF.md
# Coarse/Fine Gray Position Merger

This block assembles a 16-bit Gray position word for an optical absolute angle sensor. It takes three groups of inputs: eleven coarse track bits in Gray order, a quadrature pair of fine square waves, and four interpolated sub-step bits. The word it forms is the one a serial shift stage later sends out.

The coarse comparators do not switch at exactly the same angle as the fine pair. Near a coarse transition, the raw coarse bits can therefore lead or lag the fine edges by one coarse step. When correction is enabled, the block uses the quadrant of the fine pair to decide which way the coarse value has slipped. It then moves the coarse value one step so that all coarse transitions line up with the fine edges. When correction is disabled, the raw bits are simply concatenated.

The interpolated bits are never corrected. The output is registered once per clock.

Top module: `gray_track_merger`

## Requirements
- R1: With `corr_en`=0, `pos_word[15:5]` equals `coarse_gray` one clock after it is sampled, whatever the fine inputs are.
- R2: With `corr_en`=1, the coarse binary value is C and its LSB is C[0], where the binary is formed by the XOR prefix from the top Gray bit. If C[0] equals `fine_b`, then `pos_word[15:5]` equals `coarse_gray` unchanged.
- R3: With `corr_en`=1, let C[0] differ from `fine_b` while `fine_a`^`fine_b`=0. The coarse value is then treated as lagging, and `pos_word[15:5]` is the Gray code of C+1.
- R4: With `corr_en`=1, let C[0] differ from `fine_b` while `fine_a`^`fine_b`=1. The coarse value is then treated as leading, and `pos_word[15:5]` is the Gray code of C-1.
- R5: The coarse adjustment wraps modulo 2048. With correction, 2047+1 gives 0 and 0-1 gives 2047.
- R6: `pos_word[4]` equals `fine_a` in both modes.
- R7: `pos_word[3:0]` equals `interp[3:0]` unchanged in both modes, with `interp[3]` being the most significant interpolated bit.
- R8: `pos_word` is zero while `rst_n` is low. After reset, every output reflects the inputs sampled at the previous rising clock edge.
- R9: With `corr_en`=1, the binary LSB of the output coarse field (the XOR of `pos_word[15:5]`) always equals `fine_b`.
- R10: Consider a position that advances one step at a time while the coarse tracks lead or lag by one coarse step at their transitions. With correction on, successive 12-bit output codes `pos_word[15:4]` differ in exactly one bit, including across the 4095-to-0 wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| corr_en | input | 1 | 1 enables coarse-to-fine alignment |
| coarse_gray | input | 11 | Coarse track bits, bit 10 most significant |
| fine_a | input | 1 | Fine quadrature signal, also the 12-bit Gray LSB |
| fine_b | input | 1 | Fine quadrature signal shifted by a quarter period |
| interp | input | 4 | Interpolated sub-step bits, bit 3 most significant |
| pos_word | output | 16 | Registered merged Gray position |

## Verification
The bench goes after the edges of the adjustment: the top coarse code with a lag, which must wrap to zero, and the zero code with a lead, which must wrap to all ones. A design that saturates or carries into a missing bit would report a far-off angle there.

The bench also drives mismatching fine phases with correction off. A design that corrects anyway would move the coarse field when it should pass it through.

Finally, a skewed full-turn sweep shows that picking the wrong direction from the fine quadrant breaks the one-bit-per-step property: the coarse field jumps two steps at every transition.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
   typedef enum logic [1:0] {
      ADJ_HOLD = 2'd0,
      ADJ_UP   = 2'd1,
      ADJ_DOWN = 2'd2
   } adj_e;
endpackage

// File: rtl/gcm_gray2bin.sv
module gcm_gray2bin #(
   parameter int W = 11
) (
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin_o[i] = ^gray_i[W-1:i];
   end
endmodule

// File: rtl/gcm_bin2gray.sv
module gcm_bin2gray #(
   parameter int W = 11
) (
   input  logic [W-1:0] bin_i,
   output logic [W-1:0] gray_o
);
   assign gray_o[W-1] = bin_i[W-1];
   for (genvar i = 0; i < W-1; i++) begin : g_bit
      assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
   end
endmodule

// File: rtl/gcm_fine_align.sv
module gcm_fine_align
   import gcm_pkg::*;
#(
   parameter int W = 11
) (
   input  logic         en_i,
   input  logic         quad_a_i,
   input  logic         quad_b_i,
   input  logic [W-1:0] coarse_bin_i,
   output logic [W-1:0] aligned_bin_o
);
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   adj_e adj;
   logic sub_phase;

   // Low bit of the fine binary position inside one coarse half-period.
   assign sub_phase = quad_a_i ^ quad_b_i;

   always_comb begin
      adj = ADJ_HOLD;
      if (en_i && (coarse_bin_i[0] != quad_b_i)) begin
         adj = sub_phase ? ADJ_DOWN : ADJ_UP;
      end
   end

   always_comb begin
      unique case (adj)
         ADJ_UP:   aligned_bin_o = coarse_bin_i + ONE;
         ADJ_DOWN: aligned_bin_o = coarse_bin_i - ONE;
         default:  aligned_bin_o = coarse_bin_i;
      endcase
   end
endmodule

// File: rtl/gray_track_merger.sv
module gray_track_merger #(
   parameter int COARSE_W = 11,
   parameter int INTERP_W = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               corr_en,
   input  logic [COARSE_W-1:0]                coarse_gray,
   input  logic                               fine_a,
   input  logic                               fine_b,
   input  logic [INTERP_W-1:0]                interp,
   output logic [COARSE_W+INTERP_W:0]         pos_word
);
   localparam int OUT_W    = COARSE_W + 1 + INTERP_W;
   localparam int FINE_POS = INTERP_W;

   if (COARSE_W < 2) begin : g_chk_coarse
      $error("COARSE_W must be at least 2");
   end
   if (INTERP_W < 1) begin : g_chk_interp
      $error("INTERP_W must be at least 1");
   end
   if (FINE_POS != OUT_W - COARSE_W - 1) begin : g_chk_layout
      $error("field layout inconsistent");
   end

   logic [COARSE_W-1:0] coarse_bin;
   logic [COARSE_W-1:0] aligned_bin;
   logic [COARSE_W-1:0] aligned_gray;
   logic [OUT_W-1:0]    word_d;

   gcm_gray2bin #(.W(COARSE_W)) u_g2b (
      .gray_i (coarse_gray),
      .bin_o  (coarse_bin)
   );

   gcm_fine_align #(.W(COARSE_W)) u_align (
      .en_i          (corr_en),
      .quad_a_i      (fine_a),
      .quad_b_i      (fine_b),
      .coarse_bin_i  (coarse_bin),
      .aligned_bin_o (aligned_bin)
   );

   gcm_bin2gray #(.W(COARSE_W)) u_b2g (
      .bin_i  (aligned_bin),
      .gray_o (aligned_gray)
   );

   assign word_d = {aligned_gray, fine_a, interp};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_word <= '0;
      else        pos_word <= word_d;
   end
endmodule

// File: rtl/gray_track_merger_chk.sv
module gray_track_merger_chk #(
   parameter int COARSE_W = 11,
   parameter int INTERP_W = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       corr_en,
   input logic [COARSE_W-1:0]        coarse_gray,
   input logic                       fine_a,
   input logic                       fine_b,
   input logic [INTERP_W-1:0]        interp,
   input logic [COARSE_W+INTERP_W:0] pos_word
);
   localparam int TOP = COARSE_W + INTERP_W;

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      primed && !corr_en |=> pos_word[TOP:INTERP_W+1] == $past(coarse_gray));

   a_r2_hold_when_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      primed && corr_en && ((^coarse_gray) == fine_b)
      |=> pos_word[TOP:INTERP_W+1] == $past(coarse_gray));

   a_r6_fine_bit: assert property (@(posedge clk) disable iff (!rst_n)
      primed |=> pos_word[INTERP_W] == $past(fine_a));

   a_r7_interp_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      primed |=> pos_word[INTERP_W-1:0] == $past(interp));

   a_r9_lsb_matches_fine: assert property (@(posedge clk) disable iff (!rst_n)
      primed && corr_en |=> (^pos_word[TOP:INTERP_W+1]) == $past(fine_b));
endmodule

bind gray_track_merger gray_track_merger_chk #(
   .COARSE_W(COARSE_W),
   .INTERP_W(INTERP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .corr_en     (corr_en),
   .coarse_gray (coarse_gray),
   .fine_a      (fine_a),
   .fine_b      (fine_b),
   .interp      (interp),
   .pos_word    (pos_word)
);

// File: tb/gray_track_merger_bench.sv
module gray_track_merger_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        corr_en = 1'b0;
   logic [10:0] coarse_gray = '0;
   logic        fine_a = 1'b0;
   logic        fine_b = 1'b0;
   logic [3:0]  interp = '0;
   logic [15:0] pos_word;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gray_track_merger u_gray_track_merger (
      .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .coarse_gray(coarse_gray),
      .fine_a(fine_a), .fine_b(fine_b), .interp(interp), .pos_word(pos_word)
   );

   function automatic logic [10:0] to_gray(input logic [10:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [10:0] to_bin(input logic [10:0] g);
      logic [10:0] b;
      b[10] = g[10];
      for (int i = 9; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   function automatic logic [15:0] model(input logic en, input logic [10:0] cg,
                                         input logic a, input logic b, input logic [3:0] ip);
      logic [10:0] c;
      c = to_bin(cg);
      if (en && (c[0] != b)) c = (a ^ b) ? c - 11'd1 : c + 11'd1;
      return en ? {to_gray(c), a, ip} : {cg, a, ip};
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic en, input logic [10:0] cg,
                        input logic a, input logic b, input logic [3:0] ip);
      @(negedge clk);
      corr_en = en; coarse_gray = cg; fine_a = a; fine_b = b; interp = ip;
      @(negedge clk);
      check(req, pos_word, model(en, cg, a, b, ip));
   endtask

   initial begin
      logic [11:0] prev;
      logic [11:0] cur;
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      check("R8 reset", pos_word, 16'h0000);
      rst_n = 1'b1;

      // R1: mismatch with correction off passes coarse bits untouched
      apply("R1", 1'b0, 11'h3a5, 1'b0, 1'b0, 4'h9);
      apply("R1", 1'b0, 11'h001, 1'b1, 1'b0, 4'h6);
      // R2: aligned coarse LSB keeps value
      apply("R2", 1'b1, to_gray(11'd100), 1'b0, 1'b0, 4'h3);
      apply("R2", 1'b1, to_gray(11'd101), 1'b0, 1'b1, 4'hc);
      // R3: lag, step up
      apply("R3", 1'b1, to_gray(11'd100), 1'b1, 1'b1, 4'h0);
      // R4: lead, step down
      apply("R4", 1'b1, to_gray(11'd100), 1'b0, 1'b1, 4'hf);
      // R5: wrap both ways
      apply("R5", 1'b1, to_gray(11'd2047), 1'b0, 1'b0, 4'h5);
      check("R5 up-wrap", pos_word[15:5], 16'h0000);
      apply("R5", 1'b1, to_gray(11'd0), 1'b0, 1'b1, 4'ha);
      check("R5 down-wrap", {5'd0, to_bin(pos_word[15:5])}, 16'd2047);
      // R6/R7: fine bit and interp positions
      apply("R6 R7", 1'b1, 11'h7ff, 1'b1, 1'b0, 4'h8);
      check("R6", {15'd0, pos_word[4]}, 16'd1);
      check("R7", {12'd0, pos_word[3:0]}, 16'h8);

      // Random mix, R9 included
      for (int n = 0; n < 400; n++) begin
         logic [10:0] cg;
         logic a, b, en;
         cg = 11'($urandom); a = 1'($urandom); b = 1'($urandom); en = 1'($urandom);
         apply("R1-R7 random", en, cg, a, b, 4'($urandom));
         if (en) check("R9", {15'd0, ^pos_word[15:5]}, {15'd0, b});
      end

      // R10: skewed sweep over a turn plus wrap
      prev = '0;
      for (int p = 0; p < 4100; p++) begin
         logic [11:0] pos;
         logic [10:0] c;
         int skew;
         pos = 12'(p);
         c = pos[11:1];
         skew = $urandom_range(0, 2);
         if (skew == 1 && pos[0] == 1'b0) c = c - 11'd1;
         if (skew == 2 && pos[0] == 1'b1) c = c + 11'd1;
         apply("R10 sweep", 1'b1, to_gray(c), pos[1] ^ pos[0], pos[1], 4'($urandom));
         cur = pos_word[15:4];
         check("R10 code", {4'd0, cur}, {4'd0, pos ^ (pos >> 1)});
         if (p > 0) check("R10 one-bit step", 16'($countones(cur ^ prev)), 16'd1);
         prev = cur;
      end

      // R8: reset clears a non-zero word
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R8 async clear", pos_word, 16'h0000);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: got hang expected completion");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule